// File: doc/BRIEF.md
# Scrolling Colour Bar Test-Pattern Generator

This block makes video pixels on its own, inside the display controller, so a display path can be checked without a frame buffer or an upstream pixel source. When enabled it replaces the incoming pixels with either eight vertical colour bars or one solid colour at 12 bits per channel. The bars can move one colour position to the right every N frames.

Frame timing comes from one of two places. The block can follow the upstream timing strobes (hsync, vsync, data-enable), or it can use a small internal timing generator whose geometry is set by parameters. Settings are presented on two staged configuration words. They reach the live configuration only when the commit strobe is pulsed. When the generator is off, upstream timing and pixels pass through with the same one-cycle latency.

Top module: `cbar_pattern_gen`

## Requirements
- R1: Changes on the staged words have no effect until `commitStrobe` is high at a rising clock edge. That edge loads both words into the live configuration, and outputs registered at later edges use it.
- R2: While reset is asserted, every output is 0. While the live enable is 0, each output equals the matching upstream input from one cycle earlier (`inHsync`, `inVsync`, `inDe`, `inPixel`).
- R3: Staged word 0 layout: bit 0 enable, bits 8:1 scroll rate, bit 9 internal timing, bit 10 solid mode (0 = bars), bits 23:12 red. Staged word 1 layout: bits 23:12 green, bits 11:0 blue. Pixels are packed {red, green, blue}, with red in the top 12 bits.
- R4: In bar mode there are 8 bars, each H_ACTIVE/8 columns wide. Column c of a data-enable run lies at position p = c/(H_ACTIVE/8), and it shows colour index (p - offset) mod 8. The colour indices are: 0 white, 1 yellow, 2 cyan, 3 green, 4 magenta, 5 red, 6 blue, 7 black. Every channel is either FFF or 000.
- R5: In solid mode, every active pixel equals the committed {red, green, blue} values, so any 12-bit value is possible (for example orange FFF/800/000, cyan 000/800/800, purple 800/000/800).
- R6: While enabled, any cycle whose selected data-enable is low outputs pixel 0.
- R7: When enabled with internal timing off, the output sync and data-enable equal the upstream ones one cycle later. The column count restarts at 0 on the first data-enable cycle of each run.
- R8: When enabled with internal timing on, the upstream inputs are ignored. The generator counts column h over 0..H_TOTAL-1 and line v over 0..V_TOTAL-1, both starting at 0 on the first edge after the commit. Data-enable is high for h < H_ACTIVE and v < V_ACTIVE. Hsync is high for h >= H_TOTAL-HSYNC_LEN. Vsync is high for v >= V_TOTAL-VSYNC_LEN. All three are active high.
- R9: With a scroll rate N from 1 to 255, the bar offset increases by one every N rising edges of the selected vsync. It wraps from 7 to 0.
- R10: With a scroll rate of 0, the bar offset never changes.
- R11: A commit clears the bar offset and the frame count to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWord0 | input | 32 | Staged word 0: enable, rate, timing select, mode, red |
| cfgWord1 | input | 32 | Staged word 1: green, blue |
| commitStrobe | input | 1 | Loads the staged words into the live configuration |
| inHsync | input | 1 | Upstream horizontal sync |
| inVsync | input | 1 | Upstream vertical sync |
| inDe | input | 1 | Upstream data-enable |
| inPixel | input | 36 | Upstream pixel {R,G,B} |
| outHsync | output | 1 | Output horizontal sync |
| outVsync | output | 1 | Output vertical sync |
| outDe | output | 1 | Output data-enable |
| outPixel | output | 36 | Output pixel {R,G,B} |

## Verification
The hardest state to reach is a wrap of the scroll offset at a rate above one. The offset only moves after several vsync rising edges, and it must not move on any other vsync activity. The bench drives exact counts of short upstream vsync pulses at rate 2, checking full bar lines after 2, 14 and 16 pulses. In internal-timing mode, the bench independently counts line-start frame edges over two full frames while the upstream pins carry random noise.

// File: rtl/cbar_pkg.sv
package cbar_pkg;

  // Live control handed from the control block to the datapath
  typedef struct packed {
    logic       enable;
    logic       selfTime;
    logic       solid;
    logic       runTiming;
    logic [2:0] scrollOfs;
  } cbarCtlT;

  // Per-channel full/zero mask {r,g,b} for a bar colour index
  function automatic logic [2:0] barMask(input logic [2:0] idx);
    logic [2:0] m;
    case (idx)
      3'd0:    m = 3'b111;
      3'd1:    m = 3'b110;
      3'd2:    m = 3'b011;
      3'd3:    m = 3'b010;
      3'd4:    m = 3'b101;
      3'd5:    m = 3'b100;
      3'd6:    m = 3'b001;
      default: m = 3'b000;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/cbar_self_timing.sv
module cbar_self_timing #(
  parameter int H_ACTIVE  = 16,
  parameter int H_TOTAL   = 24,
  parameter int V_ACTIVE  = 4,
  parameter int V_TOTAL   = 6,
  parameter int HSYNC_LEN = 2,
  parameter int VSYNC_LEN = 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       run,
  output logic [$clog2(H_TOTAL)-1:0] hCount,
  output logic                       genHs,
  output logic                       genVs,
  output logic                       genDe
);
  localparam int HW = $clog2(H_TOTAL);
  localparam int VW = $clog2(V_TOTAL);
  localparam logic [HW-1:0] H_LAST   = HW'(H_TOTAL - 1);
  localparam logic [VW-1:0] V_LAST   = VW'(V_TOTAL - 1);
  localparam logic [HW-1:0] H_ACT    = HW'(H_ACTIVE);
  localparam logic [VW-1:0] V_ACT    = VW'(V_ACTIVE);
  localparam logic [HW-1:0] HS_START = HW'(H_TOTAL - HSYNC_LEN);
  localparam logic [VW-1:0] VS_START = VW'(V_TOTAL - VSYNC_LEN);

  logic [HW-1:0] hQ;
  logic [VW-1:0] vQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hQ <= '0;
      vQ <= '0;
    end else if (!run) begin
      hQ <= '0;
      vQ <= '0;
    end else if (hQ == H_LAST) begin
      hQ <= '0;
      vQ <= (vQ == V_LAST) ? '0 : vQ + 1'b1;
    end else begin
      hQ <= hQ + 1'b1;
    end
  end

  assign hCount = hQ;
  assign genDe  = (hQ < H_ACT) && (vQ < V_ACT);
  assign genHs  = (hQ >= HS_START);
  assign genVs  = (vQ >= VS_START);

endmodule

// File: rtl/cbar_ctrl.sv
module cbar_ctrl
  import cbar_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [31:0]     cfgWord0,
  input  logic [31:0]     cfgWord1,
  input  logic            commit,
  input  logic            inVsync,
  input  logic            genVs,
  output cbarCtlT         ctl,
  output logic [3*CW-1:0] solidRgb
);
  localparam int RATE_W  = 8;
  localparam int EN_BIT  = 0;
  localparam int RATE_LO = 1;
  localparam int SELF_BIT = 9;
  localparam int SOLID_BIT = 10;
  localparam int HI_LO   = 12;
  localparam int LO_LO   = 0;

  logic              enQ, selfQ, solidQ, vsPrevQ;
  logic [RATE_W-1:0] rateQ, frameQ;
  logic [2:0]        ofsQ;
  logic [CW-1:0]     redQ, greenQ, blueQ;
  logic              selVs, vsRise, lastFrame;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enQ <= 1'b0; selfQ <= 1'b0; solidQ <= 1'b0;
      rateQ <= '0; redQ <= '0; greenQ <= '0; blueQ <= '0;
    end else if (commit) begin
      enQ    <= cfgWord0[EN_BIT];
      rateQ  <= cfgWord0[RATE_LO +: RATE_W];
      selfQ  <= cfgWord0[SELF_BIT];
      solidQ <= cfgWord0[SOLID_BIT];
      redQ   <= cfgWord0[HI_LO +: CW];
      greenQ <= cfgWord1[HI_LO +: CW];
      blueQ  <= cfgWord1[LO_LO +: CW];
    end
  end

  assign selVs     = selfQ ? genVs : inVsync;
  assign vsRise    = selVs && !vsPrevQ;
  assign lastFrame = (frameQ == rateQ - 1'b1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vsPrevQ <= 1'b0;
      frameQ  <= '0;
      ofsQ    <= '0;
    end else begin
      vsPrevQ <= selVs;
      if (commit) begin
        frameQ <= '0;
        ofsQ   <= '0;
      end else if (enQ && (rateQ != '0) && vsRise) begin
        if (lastFrame) begin
          frameQ <= '0;
          ofsQ   <= ofsQ + 1'b1;
        end else begin
          frameQ <= frameQ + 1'b1;
        end
      end
    end
  end

  always_comb begin
    ctl.enable    = enQ;
    ctl.selfTime  = selfQ;
    ctl.solid     = solidQ;
    ctl.runTiming = enQ && selfQ;
    ctl.scrollOfs = ofsQ;
  end

  assign solidRgb = {redQ, greenQ, blueQ};

endmodule

// File: rtl/cbar_datapath.sv
module cbar_datapath
  import cbar_pkg::*;
#(
  parameter int CW       = 12,
  parameter int H_ACTIVE = 16,
  parameter int H_TOTAL  = 24
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  cbarCtlT                    ctl,
  input  logic [3*CW-1:0]            solidRgb,
  input  logic                       inHsync,
  input  logic                       inVsync,
  input  logic                       inDe,
  input  logic [3*CW-1:0]            inPixel,
  input  logic                       genHs,
  input  logic                       genVs,
  input  logic                       genDe,
  input  logic [$clog2(H_TOTAL)-1:0] genCol,
  output logic                       outHsync,
  output logic                       outVsync,
  output logic                       outDe,
  output logic [3*CW-1:0]            outPixel
);
  localparam int HW = $clog2(H_TOTAL);
  localparam int PW = 3 * CW;
  localparam logic [HW-1:0] BAR_W = HW'(H_ACTIVE / 8);
  localparam logic [HW-1:0] POS_MAX = HW'(7);

  logic [HW-1:0] colQ, column, posFull;
  logic [2:0]    pos, barIdx, mask;
  logic          selHs, selVs, selDe;
  logic [PW-1:0] barPix, genPix;

  // Column within the current upstream data-enable run
  always_ff @(posedge clk) begin
    if (!rstN)          colQ <= '0;
    else if (!inDe)     colQ <= '0;
    else if (colQ != '1) colQ <= colQ + 1'b1;
  end

  always_comb begin
    selHs   = ctl.selfTime ? genHs  : inHsync;
    selVs   = ctl.selfTime ? genVs  : inVsync;
    selDe   = ctl.selfTime ? genDe  : inDe;
    column  = ctl.selfTime ? genCol : colQ;
    posFull = column / BAR_W;
    pos     = (posFull > POS_MAX) ? 3'd7 : posFull[2:0];
    barIdx  = pos - ctl.scrollOfs;
    mask    = barMask(barIdx);
    barPix  = {{CW{mask[2]}}, {CW{mask[1]}}, {CW{mask[0]}}};
    genPix  = !selDe ? '0 : (ctl.solid ? solidRgb : barPix);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outHsync <= 1'b0; outVsync <= 1'b0; outDe <= 1'b0; outPixel <= '0;
    end else if (ctl.enable) begin
      outHsync <= selHs; outVsync <= selVs; outDe <= selDe; outPixel <= genPix;
    end else begin
      outHsync <= inHsync; outVsync <= inVsync; outDe <= inDe; outPixel <= inPixel;
    end
  end

endmodule

// File: rtl/cbar_pattern_gen.sv
module cbar_pattern_gen
  import cbar_pkg::*;
#(
  parameter int CW        = 12,
  parameter int H_ACTIVE  = 16,
  parameter int H_TOTAL   = 24,
  parameter int V_ACTIVE  = 4,
  parameter int V_TOTAL   = 6,
  parameter int HSYNC_LEN = 2,
  parameter int VSYNC_LEN = 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [31:0]     cfgWord0,
  input  logic [31:0]     cfgWord1,
  input  logic            commitStrobe,
  input  logic            inHsync,
  input  logic            inVsync,
  input  logic            inDe,
  input  logic [3*CW-1:0] inPixel,
  output logic            outHsync,
  output logic            outVsync,
  output logic            outDe,
  output logic [3*CW-1:0] outPixel
);
  localparam int HW = $clog2(H_TOTAL);

  cbarCtlT         ctl;
  logic [3*CW-1:0] solidRgb;
  logic [HW-1:0]   genCol;
  logic            genHs, genVs, genDe;

  cbar_ctrl #(.CW(CW)) uCtrl (
    .clk(clk), .rstN(rstN), .cfgWord0(cfgWord0), .cfgWord1(cfgWord1),
    .commit(commitStrobe), .inVsync(inVsync), .genVs(genVs),
    .ctl(ctl), .solidRgb(solidRgb)
  );

  cbar_self_timing #(
    .H_ACTIVE(H_ACTIVE), .H_TOTAL(H_TOTAL), .V_ACTIVE(V_ACTIVE),
    .V_TOTAL(V_TOTAL), .HSYNC_LEN(HSYNC_LEN), .VSYNC_LEN(VSYNC_LEN)
  ) uTiming (
    .clk(clk), .rstN(rstN), .run(ctl.runTiming), .hCount(genCol),
    .genHs(genHs), .genVs(genVs), .genDe(genDe)
  );

  cbar_datapath #(.CW(CW), .H_ACTIVE(H_ACTIVE), .H_TOTAL(H_TOTAL)) uPath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .solidRgb(solidRgb),
    .inHsync(inHsync), .inVsync(inVsync), .inDe(inDe), .inPixel(inPixel),
    .genHs(genHs), .genVs(genVs), .genDe(genDe), .genCol(genCol),
    .outHsync(outHsync), .outVsync(outVsync), .outDe(outDe), .outPixel(outPixel)
  );

endmodule

// File: rtl/cbar_pattern_gen_chk.sv
module cbar_pattern_gen_chk
  import cbar_pkg::*;
#(
  parameter int CW = 12
) (
  input logic            clk,
  input logic            rstN,
  input logic            commit,
  input logic            inHsync,
  input logic            inVsync,
  input logic            inDe,
  input logic [3*CW-1:0] inPixel,
  input logic            outHsync,
  input logic            outVsync,
  input logic            outDe,
  input logic [3*CW-1:0] outPixel,
  input cbarCtlT         ctl,
  input logic [3*CW-1:0] solidRgb
);
  logic pastValid;
  always_ff @(posedge clk) begin
    if (!rstN) pastValid <= 1'b0;
    else       pastValid <= 1'b1;
  end

  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rstN)
    pastValid && !$past(ctl.enable) |-> outPixel == $past(inPixel) && outDe == $past(inDe)); // R2

  AST_HOLD_CONFIG: assert property (@(posedge clk) disable iff (!rstN)
    pastValid && !$past(commit) |-> $stable(ctl.enable) && $stable(ctl.selfTime)
      && $stable(ctl.solid) && $stable(solidRgb)); // R1

  AST_SOLID_FILL: assert property (@(posedge clk) disable iff (!rstN)
    pastValid && $past(ctl.enable && ctl.solid) && outDe |-> outPixel == $past(solidRgb)); // R5

  AST_BLANK_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    pastValid && $past(ctl.enable) && !outDe |-> outPixel == '0); // R6

  AST_UPSTREAM_TIMING: assert property (@(posedge clk) disable iff (!rstN)
    pastValid && $past(ctl.enable && !ctl.selfTime) |-> outHsync == $past(inHsync)
      && outVsync == $past(inVsync) && outDe == $past(inDe)); // R7

  AST_SELF_SYNC: assert property (@(posedge clk) disable iff (!rstN)
    pastValid && $past(ctl.enable && ctl.selfTime) && outDe |-> !outHsync && !outVsync); // R8

  AST_SCROLL_STEP: assert property (@(posedge clk) disable iff (!rstN)
    pastValid && !$past(commit) && ctl.scrollOfs != $past(ctl.scrollOfs)
      |-> ctl.scrollOfs == $past(ctl.scrollOfs) + 3'd1); // R9

  AST_COMMIT_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    pastValid && $past(commit) |-> ctl.scrollOfs == 3'd0); // R11

endmodule

bind cbar_pattern_gen cbar_pattern_gen_chk #(.CW(CW)) uChk (
  .clk(clk), .rstN(rstN), .commit(commitStrobe),
  .inHsync(inHsync), .inVsync(inVsync), .inDe(inDe), .inPixel(inPixel),
  .outHsync(outHsync), .outVsync(outVsync), .outDe(outDe), .outPixel(outPixel),
  .ctl(ctl), .solidRgb(solidRgb)
);

// File: tb/cbar_pattern_gen_test.sv
module cbar_pattern_gen_test;
  localparam int HA = 16, HT = 24, VA = 4, VT = 6, HSL = 2, VSL = 1, BW = HA / 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] cfg0 = '0, cfg1 = '0;
  logic        commit = 1'b0;
  logic        inHs = 1'b0, inVs = 1'b0, inDe = 1'b0;
  logic [35:0] inPix = '0;
  logic        outHs, outVs, outDe;
  logic [35:0] outPix;
  int          checks = 0, errors = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  cbar_pattern_gen uut (
    .clk(clk), .rstN(rstN), .cfgWord0(cfg0), .cfgWord1(cfg1), .commitStrobe(commit),
    .inHsync(inHs), .inVsync(inVs), .inDe(inDe), .inPixel(inPix),
    .outHsync(outHs), .outVsync(outVs), .outDe(outDe), .outPixel(outPix)
  );

  function automatic logic [31:0] mkW0(bit en, logic [7:0] rate, bit slf, bit sol, logic [11:0] r);
    return {8'h00, r, 1'b0, sol, slf, rate, en};
  endfunction
  function automatic logic [31:0] mkW1(logic [11:0] g, logic [11:0] b);
    return {8'h00, g, b};
  endfunction
  function automatic logic [35:0] barExp(int idx);
    case (idx & 7)
      0: return {12'hFFF, 12'hFFF, 12'hFFF};
      1: return {12'hFFF, 12'hFFF, 12'h000};
      2: return {12'h000, 12'hFFF, 12'hFFF};
      3: return {12'h000, 12'hFFF, 12'h000};
      4: return {12'hFFF, 12'h000, 12'hFFF};
      5: return {12'hFFF, 12'h000, 12'h000};
      6: return {12'h000, 12'h000, 12'hFFF};
      default: return 36'h0;
    endcase
  endfunction

  task automatic chk(input logic [35:0] act, input logic [35:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drive one cycle at a falling edge, then sample after the next rising edge
  task automatic step(input bit hs, input bit vs, input bit de, input logic [35:0] px);
    inHs = hs; inVs = vs; inDe = de; inPix = px;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic doCommit(input logic [31:0] w0, input logic [31:0] w1);
    cfg0 = w0; cfg1 = w1; commit = 1'b1;
    step(0, 0, 0, '0);
    commit = 1'b0;
  endtask

  task automatic vsPulse();
    step(0, 1, 0, '0);
    step(0, 0, 0, '0);
  endtask

  task automatic barLine(input int ofs, input string tag);
    for (int c = 0; c < HA; c++) begin
      step(0, 0, 1, 36'h123456789);
      chk(outPix, barExp((c / BW) - ofs), tag);
    end
    step(0, 0, 0, '0);
  endtask

  task automatic testReset();
    inHs = 1; inVs = 1; inDe = 1; inPix = 36'hABCDEF012;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk({outHs, outVs, outDe, outPix}, '0, "R2 reset outputs zero");
    rstN = 1'b1;
  endtask

  task automatic testPass(input string tag);
    for (int i = 0; i < 6; i++) begin
      logic [35:0] p = {$urandom, $urandom};
      bit hs = 1'($urandom), vs = 1'($urandom), de = 1'($urandom);
      step(hs, vs, de, p);
      chk({outHs, outVs, outDe, outPix}, {hs, vs, de, p}, tag);
    end
  endtask

  task automatic testNoCommit();
    cfg0 = mkW0(1, 0, 0, 1, 12'hFFF); cfg1 = mkW1(12'h800, 12'h000);
    step(0, 0, 1, 36'h00000_0055);
    chk(outPix, 36'h00000_0055, "R1 staged word ignored without commit");
  endtask

  task automatic testBars();
    doCommit(mkW0(1, 0, 0, 0, 12'h000), '0);
    barLine(0, "R4 bar colours offset 0");
    step(1, 0, 0, 36'hFFFFFFFFF);
    chk({35'h0, outHs}, 36'h1, "R7 hsync follows upstream");
    chk(outPix, '0, "R6 blank pixel zero");
    step(0, 1, 1, 36'h0);
    chk({34'h0, outVs, outDe}, 36'h3, "R7 vsync and de follow upstream");
    step(0, 0, 0, '0);
    repeat (3) vsPulse();
    barLine(0, "R10 rate zero stays static");
  endtask

  task automatic testScroll();
    doCommit(mkW0(1, 8'd2, 0, 0, 12'h000), '0);
    vsPulse();
    barLine(0, "R9 one edge at rate 2 no step");
    vsPulse();
    barLine(1, "R9 two edges at rate 2 step 1");
    repeat (12) vsPulse();
    barLine(7, "R9 offset 7");
    repeat (2) vsPulse();
    barLine(0, "R9 offset wraps to 0");
    doCommit(mkW0(1, 8'd1, 0, 0, 12'h000), '0);
    repeat (3) vsPulse();
    barLine(3, "R9 rate 1 three edges");
    doCommit(mkW0(1, 8'd1, 0, 0, 12'h000), '0);
    barLine(0, "R11 commit clears offset");
  endtask

  task automatic solidOne(input logic [11:0] r, input logic [11:0] g, input logic [11:0] b, input string tag);
    doCommit(mkW0(1, 0, 0, 1, r), mkW1(g, b));
    for (int c = 0; c < 3; c++) begin
      step(0, 0, 1, 36'h0);
      chk(outPix, {r, g, b}, tag);
    end
    step(0, 0, 0, '0);
  endtask

  task automatic testSolid();
    solidOne(12'hFFF, 12'h800, 12'h000, "R5 R3 orange");
    solidOne(12'h000, 12'h800, 12'h800, "R5 R3 cyan");
    solidOne(12'h800, 12'h000, 12'h800, "R5 R3 purple");
    solidOne(12'h123, 12'h456, 12'h789, "R5 R3 arbitrary");
  endtask

  task automatic testSelf();
    int rises = 0;
    doCommit(mkW0(1, 8'd1, 1, 0, 12'h000), '0);
    for (int i = 0; i < 2 * HT * VT + 5; i++) begin
      int h = i % HT;
      int v = (i / HT) % VT;
      bit eDe = (h < HA) && (v < VA);
      bit eHs = (h >= HT - HSL);
      bit eVs = (v >= VT - VSL);
      step(1'($urandom), 1'($urandom), 1'($urandom), {$urandom, $urandom});
      chk({33'h0, outHs, outVs, outDe}, {33'h0, eHs, eVs, eDe}, "R8 internal timing");
      chk(outPix, eDe ? barExp((h / BW) - rises) : 36'h0, "R8 R9 internal bars");
      if (v == VT - VSL && h == 0) rises++;
    end
  endtask

  initial begin
    @(negedge clk);
    testReset();
    @(negedge clk);
    testPass("R2 pass through after reset");
    testNoCommit();
    testBars();
    testScroll();
    testSolid();
    testSelf();
    doCommit('0, '0);
    testPass("R2 pass through after disable");
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule